// File: doc/BRIEF.md
# Byte-Serial SPI Master with Register Access

This block is an SPI master that a processor drives through a small 32-bit register port. Bytes written to the data register queue in a 16-entry transmit FIFO. While the transfer-active bit is set, the shifter pulls them out one at a time and clocks them out MSB first on the serial data line. It drives one of three chip selects and captures each incoming byte into a 16-entry receive FIFO, which is read back through the same data register. The serial clock is the core clock divided by an even divider. Every byte is followed by one idle serial-clock period, so one byte takes exactly nine serial-clock periods.

The control word holds the clock mode (idle level and sampling phase), the chip-select field, a shared polarity bit and one polarity bit for each select, the transfer-active bit, two interrupt enables, a 3-wire read-enable and two self-clearing FIFO flush bits. The upper half of the same word reports the FIFO and completion status. A 16-bit length register counts down once for each completed byte. One interrupt line combines "transfer drained" with "receive FIFO needs reading".

The register port uses `reg_we` and `reg_re` as single-cycle valid strobes and is always ready, so there is no back-pressure handshake. The flow limit is shown in the status bits instead. A data write that finds the transmit FIFO full is dropped. A data read from an empty receive FIFO returns 0 and pops nothing. Read data is combinational from `reg_addr`.

Top module: `spim_ctrl`

## Requirements
- R1: After reset, every control field is 0, all three chip selects sit at their inactive level (high), `sclk` is 0, `irq` is 0, `mosi_oe` is 1, and the control word reads 0x0004_0000 (only the "transmit can accept" status bit, bit 18, is set).
- R2: Writing the control word with bit 4 set empties the transmit FIFO, and with bit 5 set empties the receive FIFO. The flush takes effect at the write edge. Bits 4 and 5 always read back 0.
- R3: Bit 16 (done) reads 1 whenever transfer-active (bit 7) is 1, the transmit FIFO is empty and the shifter is idle. When the done-interrupt enable (bit 9) is also 1, `irq` is high in the first cycle after the write that set transfer-active.
- R4: With divider value D (register at 0x08, bit 0 ignored, 0 meaning 65536), each `sclk` half period lasts D/2 core clocks. Consecutive bytes start exactly 9·D core clocks apart. Clearing transfer-active stops the shifter at once, and `sclk` returns to its idle level, which is the CPOL bit (bit 3).
- R5: Bytes are shifted MSB first. With CPHA (bit 2) = 0, input data is sampled on the first `sclk` edge of each bit, and with CPHA = 1 on the second edge. Output data is stable at the sampling edge in all four clock modes, so a looped-back line returns the sent byte.
- R6: The chip-select field (bits 1:0) asserts select 0, 1 or 2 only while transfer-active is 1. Code 3 asserts none. The active level of select i is 1 when its polarity bit (bit 21+i) or the shared polarity bit (bit 6) is set, and 0 otherwise. A select that is not asserted drives the opposite level.
- R7: With read-enable (bit 12) set, `mosi_oe` is 0 and the received bits come from `mosi_i` instead of `miso_i`. Transmit bytes still generate clocks.
- R8: Bit 19 (receive needs reading) is 1 when the receive FIFO holds 12 or more bytes, and `irq` is high while this holds with the receive-interrupt enable (bit 10) set. Bit 20 is 1 when the FIFO holds 16 bytes. A byte received while the FIFO is full is discarded.
- R9: The length register (0x0C, 16 bits) decrements by one when each byte completes, holds at 0, and takes any written value, including 0, at once.
- R10: Bit 18 is 0 when the transmit FIFO holds 16 bytes, and a further data write is dropped. Bit 17 is 1 when the receive FIFO holds data. Reading the data register (0x04) pops one received byte, or returns 0 without effect when the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (pops the receive FIFO at 0x04) |
| reg_addr | input | 4 | Byte address: 0x0 control/status, 0x4 data, 0x8 divider, 0xC length |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| irq | output | 1 | Interrupt: enabled done or enabled receive threshold |
| sclk | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| mosi_oe | output | 1 | Output enable for `mosi_o`, low in 3-wire read mode |
| mosi_i | input | 1 | Shared data line read back in 3-wire mode |
| miso_i | input | 1 | Serial data in |
| cs_o | output | 3 | Chip-select levels, one per select |

## Verification
A register write takes effect at the clock edge inside the write. Status bits, `irq`, `cs_o` and `mosi_oe` are therefore correct from the falling edge after that edge, and the bench samples them there. Serial timing is measured rather than predicted from the start latency. A monitor stamps every `sclk` transition with the cycle number and compares distances: half a divider between the first two edges, and 9·D from the first edge of one byte to the first edge of the next. A received byte lands in the FIFO on the same edge that ends its idle period. The bench therefore polls the done bit before reading data. This avoids tying its checks to an absolute cycle after the active bit is set.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int DATA_W     = 8;
  localparam int FIFO_DEPTH = 16;
  localparam int RX_THRESH  = 12;
  localparam int NUM_CS     = 3;
  localparam int DIV_W      = 16;
  localparam int LEN_W      = 16;

  typedef enum logic [3:0] {
    A_CTRL = 4'h0,
    A_DATA = 4'h4,
    A_DIV  = 4'h8,
    A_LEN  = 4'hC
  } reg_addr_e;

  // control word field positions
  localparam int B_SEL     = 0;
  localparam int B_CPHA    = 2;
  localparam int B_CPOL    = 3;
  localparam int B_CLR_TX  = 4;
  localparam int B_CLR_RX  = 5;
  localparam int B_CSPOL   = 6;
  localparam int B_ACTIVE  = 7;
  localparam int B_IE_DONE = 9;
  localparam int B_IE_RX   = 10;
  localparam int B_RDEN    = 12;
  localparam int B_DONE    = 16;
  localparam int B_RXD     = 17;
  localparam int B_TXD     = 18;
  localparam int B_RXR     = 19;
  localparam int B_RXF     = 20;
  localparam int B_SPOL    = 21;

  localparam logic [31:0] CTRL_WMASK = 32'h00E0_16CF;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH):0]     level
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] LVL_FULL = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign do_push = push && (level != LVL_FULL);
  assign do_pop  = pop && (level != '0);
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  // R8 / R10: a push into a full FIFO leaves the level unchanged
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (push && level == LVL_FULL && !pop && !flush) |=> level == LVL_FULL);
endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
  parameter int DW = 8,
  parameter int HW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          cpol,
  input  logic          cpha,
  input  logic [HW-1:0] half_div,
  input  logic          start,
  input  logic [DW-1:0] tx_byte,
  input  logic          din,
  output logic          busy,
  output logic          last_tick,
  output logic          sclk,
  output logic          mosi,
  output logic [DW-1:0] rx_byte
);
  localparam int EDGES  = 2 * DW;
  localparam int HALVES = EDGES + 2;
  localparam int CW     = $clog2(HALVES);

  logic [HW-1:0] hcnt, half_lim;
  logic [CW-1:0] h;
  logic          ph, tick;
  logic [DW-1:0] sreg, rsh;

  assign half_lim  = (half_div == '0) ? {HW{1'b1}} : half_div - 1'b1;
  assign tick      = busy && (hcnt >= half_lim);
  assign last_tick = enable && tick && (h == CW'(HALVES - 1));
  assign sclk      = cpol ^ ph;
  assign mosi      = sreg[DW-1];
  assign rx_byte   = rsh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      hcnt <= '0;
      h    <= '0;
      ph   <= 1'b0;
      sreg <= '0;
      rsh  <= '0;
    end else if (!enable) begin
      busy <= 1'b0;
      hcnt <= '0;
      h    <= '0;
      ph   <= 1'b0;
    end else begin
      if (busy) begin
        if (tick) begin
          hcnt <= '0;
          if (h < CW'(EDGES)) begin
            ph <= ~ph;
            if (h[0] == cpha)  rsh  <= {rsh[DW-2:0], din};
            else if (h != '0)  sreg <= {sreg[DW-2:0], 1'b0};
          end
          if (h == CW'(HALVES - 1)) begin
            busy <= 1'b0;
            h    <= '0;
          end else begin
            h <= h + 1'b1;
          end
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end
      if (start) begin
        busy <= 1'b1;
        sreg <= tx_byte;
        hcnt <= '0;
        h    <= '0;
        ph   <= 1'b0;
      end
    end
  end

  // R4: the half-period index never leaves the byte frame
  a_r4_frame_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> h < CW'(HALVES));
  // R4: an idle shifter holds the clock at its idle level
  a_r4_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk == cpol);
endmodule

// File: rtl/spim_csel.sv
module spim_csel #(
  parameter int N = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   active,
  input  logic [$clog2(N+1)-1:0] sel,
  input  logic                   common_pol,
  input  logic [N-1:0]           pol,
  output logic [N-1:0]           cs_o
);
  localparam int SW = $clog2(N + 1);

  logic [N-1:0] hit;

  for (genvar i = 0; i < N; i++) begin : g_sel
    logic lvl;
    assign lvl     = pol[i] | common_pol;
    assign hit[i]  = active && (sel == SW'(i));
    assign cs_o[i] = hit[i] ? lvl : ~lvl;
  end

  // R6: at most one select is driven to its active level
  a_r6_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int DEPTH  = FIFO_DEPTH,
  parameter int THRESH = RX_THRESH
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_re,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        sclk,
  output logic        mosi_o,
  output logic        mosi_oe,
  input  logic        mosi_i,
  input  logic        miso_i,
  output logic [2:0]  cs_o
);
  localparam int LW = $clog2(DEPTH) + 1;
  localparam logic [LW-1:0] LVL_FULL = LW'(DEPTH);
  localparam logic [LW-1:0] LVL_THR  = LW'(THRESH);

  logic [31:0]       ctrl_word;
  logic [DIV_W-1:0]  div_q;
  logic [LEN_W-1:0]  len_q;
  logic              wr_ctrl, wr_data, wr_div, wr_len, rd_data;
  logic              tx_flush, rx_flush;
  logic [LW-1:0]     tx_lvl, rx_lvl;
  logic [DATA_W-1:0] tx_head, rx_head, rx_byte;
  logic              tx_empty, tx_full, rx_empty, rx_full, rx_ready;
  logic              active, sh_busy, last_tick, start, done, din;
  logic [31:0]       status;

  assign wr_ctrl  = reg_we && (reg_addr == A_CTRL);
  assign wr_data  = reg_we && (reg_addr == A_DATA);
  assign wr_div   = reg_we && (reg_addr == A_DIV);
  assign wr_len   = reg_we && (reg_addr == A_LEN);
  assign rd_data  = reg_re && (reg_addr == A_DATA);
  assign tx_flush = wr_ctrl && reg_wdata[B_CLR_TX];
  assign rx_flush = wr_ctrl && reg_wdata[B_CLR_RX];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_word <= '0;
      div_q     <= '0;
      len_q     <= '0;
    end else begin
      if (wr_ctrl) ctrl_word <= reg_wdata & CTRL_WMASK;
      if (wr_div)  div_q     <= reg_wdata[DIV_W-1:0];
      if (wr_len)              len_q <= reg_wdata[LEN_W-1:0];
      else if (last_tick && len_q != '0) len_q <= len_q - 1'b1;
    end
  end

  assign active   = ctrl_word[B_ACTIVE];
  assign tx_empty = (tx_lvl == '0);
  assign tx_full  = (tx_lvl == LVL_FULL);
  assign rx_empty = (rx_lvl == '0);
  assign rx_full  = (rx_lvl == LVL_FULL);
  assign rx_ready = (rx_lvl >= LVL_THR);
  assign start    = active && !tx_empty && (!sh_busy || last_tick);
  assign done     = active && tx_empty && !sh_busy;
  assign din      = ctrl_word[B_RDEN] ? mosi_i : miso_i;
  assign mosi_oe  = !ctrl_word[B_RDEN];
  assign irq      = (done && ctrl_word[B_IE_DONE]) || (rx_ready && ctrl_word[B_IE_RX]);

  spim_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush),
    .push(wr_data), .din(reg_wdata[DATA_W-1:0]),
    .pop(start), .dout(tx_head), .level(tx_lvl)
  );

  spim_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush),
    .push(last_tick), .din(rx_byte),
    .pop(rd_data), .dout(rx_head), .level(rx_lvl)
  );

  spim_shift #(.DW(DATA_W), .HW(DIV_W-1)) u_shift (
    .clk(clk), .rst_n(rst_n), .enable(active),
    .cpol(ctrl_word[B_CPOL]), .cpha(ctrl_word[B_CPHA]),
    .half_div(div_q[DIV_W-1:1]), .start(start), .tx_byte(tx_head),
    .din(din), .busy(sh_busy), .last_tick(last_tick),
    .sclk(sclk), .mosi(mosi_o), .rx_byte(rx_byte)
  );

  spim_csel #(.N(NUM_CS)) u_csel (
    .clk(clk), .rst_n(rst_n), .active(active),
    .sel(ctrl_word[B_SEL+:2]), .common_pol(ctrl_word[B_CSPOL]),
    .pol(ctrl_word[B_SPOL+:NUM_CS]), .cs_o(cs_o)
  );

  always_comb begin
    status         = '0;
    status[B_DONE] = done;
    status[B_RXD]  = !rx_empty;
    status[B_TXD]  = !tx_full;
    status[B_RXR]  = rx_ready;
    status[B_RXF]  = rx_full;
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_word | status;
      A_DATA:  reg_rdata = rx_empty ? 32'd0 : {{(32-DATA_W){1'b0}}, rx_head};
      A_DIV:   reg_rdata = {{(32-DIV_W){1'b0}}, div_q};
      A_LEN:   reg_rdata = {{(32-LEN_W){1'b0}}, len_q};
      default: reg_rdata = '0;
    endcase
  end

  // R2: a transmit flush leaves the FIFO empty on the next cycle
  a_r2_flush_tx: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> tx_empty);
  // R3: a drained active transfer with its enable raises the interrupt
  a_r3_done_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (active && tx_empty && !sh_busy && ctrl_word[B_IE_DONE]) |-> irq);
  // R9: each completed byte takes one count off a nonzero length
  a_r9_len_step: assert property (@(posedge clk) disable iff (!rst_n)
    (last_tick && len_q != '0 && !wr_len) |=> len_q == $past(len_q) - 1'b1);
  // R7: the line is released whenever read-enable is set
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_word[B_RDEN]) |-> !mosi_oe);
endmodule

// File: tb/spim_ctrl_tb.sv
`timescale 1ns/100ps
module spim_ctrl_tb;
  localparam logic [3:0] AC = 4'h0, AD = 4'h4, AV = 4'h8, AL = 4'hC;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        irq, sclk, mosi_o, mosi_oe, sdio_drv = 1'b0;
  logic [2:0]  cs_o;

  int total = 0, fails = 0, cyc = 0, ecnt = 0;
  int e_t [64];
  logic sclk_last = 1'b0, m_cpol = 1'b0, m_cpha = 1'b0;
  logic [7:0] mon_sh = '0;
  logic [31:0] mode = '0;
  logic [7:0] txb [32];
  bit finished = 0;

  always #2 clk = ~clk;

  spim_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .sclk(sclk), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .mosi_i(sdio_drv), .miso_i(mosi_o), .cs_o(cs_o)
  );

  // serial monitor: stamps every clock transition, rebuilds data at sampling edges
  always @(posedge clk) begin
    #1;
    cyc++;
    if (sclk !== sclk_last) begin
      if (ecnt < 64) e_t[ecnt] = cyc;
      ecnt++;
      if ((sclk_last == m_cpol) == (m_cpha == 1'b0)) mon_sh = {mon_sh[6:0], mosi_o};
      sclk_last = sclk;
    end
  end

  function automatic [31:0] cw(input [1:0] sel, input cpha, input cpol, input ctx,
      input crx, input cpc, input ta, input idn, input irx, input ren, input [2:0] sp);
    return {8'h0, sp, 8'h0, ren, 1'b0, irx, idn, 1'b0, ta, cpc, crx, ctx, cpol, cpha, sel};
  endfunction

  function automatic [2:0] exp_cs(input ta, input [1:0] sel, input cpc, input [2:0] sp);
    logic [2:0] r;
    for (int i = 0; i < 3; i++) begin
      logic lvl;
      lvl = sp[i] | cpc;
      r[i] = (ta && sel == 2'(i)) ? lvl : ~lvl;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input [31:0] act, input [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input [3:0] a, input [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input [3:0] a, output [31:0] d);
    @(negedge clk); reg_re = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_re = 1'b0;
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int k = 0; k < 40000; k++) begin
      rd(AC, s);
      if (s[16]) return;
    end
    chk(1'b0, "R3 done never seen", 0, 1);
  endtask

  // queue n bytes, run them, then drop the active bit again
  task automatic run(input int n, input bit clr);
    wr(AC, mode | (clr ? 32'h30 : 32'h0));
    for (int i = 0; i < n; i++) wr(AD, {24'h0, txb[i]});
    ecnt = 0;
    wr(AC, mode | 32'h80);
    wait_done();
    wr(AC, mode);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    finish_run();
  end

  initial begin
    logic [31:0] r, dmy;
    dmy = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(AC, r);
    chk(r == 32'h0004_0000, "R1 ctrl reset value", r, 32'h0004_0000);
    chk(cs_o == 3'b111 && sclk == 1'b0, "R1 selects and clock idle", {cs_o, sclk}, 4'b1110);
    chk(irq == 1'b0 && mosi_oe == 1'b1, "R1 irq low, line driven", {irq, mosi_oe}, 2'b01);

    // R3 done and irq straight after activation with nothing queued
    wr(AC, cw(2'd3, 0, 0, 0, 0, 0, 1, 1, 0, 0, 3'b0));
    chk(irq == 1'b1, "R3 irq immediate", irq, 1);
    rd(AC, r);
    chk(r[16] == 1'b1, "R3 done bit", r[16], 1);
    chk(cs_o == 3'b111, "R6 code 3 selects none", cs_o, 3'b111);
    wr(AC, 32'h0);
    chk(irq == 1'b0, "R3 irq drops with active cleared", irq, 0);

    // R6 select decode across codes and polarities
    for (int t = 0; t < 8; t++) begin
      logic [1:0] sel; logic cpc, ta; logic [2:0] sp;
      sel = 2'($urandom % 4); cpc = 1'($urandom); ta = 1'($urandom); sp = 3'($urandom);
      wr(AC, cw(sel, 0, 0, 0, 0, cpc, ta, 0, 0, 0, sp));
      chk(cs_o == exp_cs(ta, sel, cpc, sp), "R6 select levels", cs_o, exp_cs(ta, sel, cpc, sp));
    end
    wr(AC, 32'h0);

    // R4 timing at divider 4, R5 loopback in all four clock modes
    wr(AV, 32'd4);
    for (int m = 0; m < 4; m++) begin
      m_cpha = m[0]; m_cpol = m[1];
      mode = cw(2'd0, m_cpha, m_cpol, 0, 0, 0, 0, 0, 0, 0, 3'b0);
      txb[0] = 8'($urandom); txb[1] = 8'($urandom);
      run(2, 1);
      if (m == 0) begin
        chk(e_t[1] - e_t[0] == 2, "R4 half period at D=4", e_t[1] - e_t[0], 2);
        chk(e_t[16] - e_t[0] == 36, "R4 byte spacing 9*D", e_t[16] - e_t[0], 36);
      end
      chk(mon_sh == txb[1], "R5 MSB-first bits at sampling edge", mon_sh, txb[1]);
      chk(sclk == m_cpol, "R4 idle level after transfer", sclk, m_cpol);
      for (int i = 0; i < 2; i++) begin
        rd(AD, r);
        chk(r == {24'h0, txb[i]}, "R5 loopback byte", r, txb[i]);
      end
    end

    // R4 odd divider behaves as the even value below it
    wr(AV, 32'd3);
    m_cpha = 0; m_cpol = 0; mode = cw(2'd1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3'b0);
    txb[0] = 8'hA5;
    run(1, 1);
    chk(e_t[1] - e_t[0] == 1, "R4 divider LSB ignored", e_t[1] - e_t[0], 1);
    rd(AD, r);
    chk(r == 32'hA5, "R5 byte at D=3", r, 32'hA5);

    // R2 flush of queued transmit data and of received data
    wr(AV, 32'd2);
    mode = cw(2'd3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3'b0);
    wr(AC, mode);
    for (int i = 0; i < 3; i++) wr(AD, 32'h55);
    wr(AC, mode | 32'h10);
    rd(AC, r);
    chk(r[5:4] == 2'b00, "R2 clear bits read 0", r[5:4], 0);
    ecnt = 0;
    wr(AC, mode | 32'h80);
    rd(AC, r);
    chk(r[16] == 1'b1, "R2 tx flushed so done at once", r[16], 1);
    repeat (20) @(negedge clk);
    chk(ecnt == 0, "R2 no clocks after tx flush", ecnt, 0);
    wr(AC, mode);
    txb[0] = 8'h11; txb[1] = 8'h22;
    run(2, 1);
    rd(AC, r);
    chk(r[17] == 1'b1, "R10 rx holds data", r[17], 1);
    wr(AC, mode | 32'h20);
    rd(AC, r);
    chk(r[17] == 1'b0, "R2 rx flushed", r[17], 0);

    // R7 3-wire: data comes from the shared line
    mode = cw(2'd0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 3'b0);
    sdio_drv = 1'b1; txb[0] = 8'h00;
    run(1, 1);
    chk(mosi_oe == 1'b0, "R7 line released", mosi_oe, 0);
    rd(AD, r);
    chk(r == 32'hFF, "R7 bits from shared line (ones)", r, 32'hFF);
    sdio_drv = 1'b0; txb[0] = 8'hFF;
    run(1, 1);
    rd(AD, r);
    chk(r == 32'h00, "R7 bits from shared line (zeros)", r, 32'h00);

    // R8 threshold, full and overflow drop
    mode = cw(2'd3, 0, 0, 0, 0, 0, 0, 0, 1, 0, 3'b0);
    for (int i = 0; i < 17; i++) txb[i] = 8'(8'h40 + i);
    run(11, 1);
    rd(AC, r);
    chk(r[19] == 1'b0 && irq == 1'b0, "R8 below threshold at 11", {r[19], irq}, 0);
    txb[0] = txb[11];
    run(1, 0);
    rd(AC, r);
    chk(r[19] == 1'b1 && irq == 1'b1, "R8 threshold at 12 with irq", {r[19], irq}, 2'b11);
    for (int i = 0; i < 5; i++) txb[i] = 8'(8'h40 + 12 + i);
    run(5, 0);
    rd(AC, r);
    chk(r[20] == 1'b1, "R8 rx full at 16", r[20], 1);
    for (int i = 0; i < 16; i++) begin
      rd(AD, r);
      chk(r == 32'(8'h40 + i), "R8 kept bytes in order", r, 32'(8'h40 + i));
    end
    rd(AC, r);
    chk(r[17] == 1'b0, "R8 overflow byte discarded", r[17], 0);
    rd(AD, r);
    chk(r == 32'h0, "R10 empty read returns 0", r, 0);

    // R10 transmit full, extra write dropped
    mode = cw(2'd3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3'b0);
    wr(AC, mode | 32'h30);
    for (int i = 0; i < 17; i++) wr(AD, 32'(8'h80 + i));
    rd(AC, r);
    chk(r[18] == 1'b0, "R10 tx full flag", r[18], 0);
    wr(AC, mode | 32'h80);
    wait_done();
    wr(AC, mode);
    for (int i = 0; i < 16; i++) begin
      rd(AD, r);
      chk(r == 32'(8'h80 + i), "R10 first sixteen sent", r, 32'(8'h80 + i));
    end
    rd(AC, r);
    chk(r[17] == 1'b0, "R10 seventeenth write dropped", r[17], 0);

    // R9 length counter
    wr(AL, 32'd5);
    run(3, 1);
    rd(AL, r);
    chk(r == 32'd2, "R9 length after 3 bytes", r, 2);
    run(3, 1);
    rd(AL, r);
    chk(r == 32'd0, "R9 length holds at 0", r, 0);
    wr(AL, 32'd9); wr(AL, 32'd0);
    rd(AL, r);
    chk(r == 32'd0, "R9 write of 0", r, 0);

    // random transfers
    for (int it = 0; it < 12; it++) begin
      int n;
      m_cpha = 1'($urandom); m_cpol = 1'($urandom);
      mode = cw(2'($urandom % 3), m_cpha, m_cpol, 0, 0, 0, 0, 0, 0, 0, 3'b0);
      wr(AV, 32'(2 * (1 + $urandom % 4)));
      n = 1 + $urandom % 6;
      for (int i = 0; i < n; i++) txb[i] = 8'($urandom);
      run(n, 1);
      chk(mon_sh == txb[n-1], "R5 random last byte on line", mon_sh, txb[n-1]);
      for (int i = 0; i < n; i++) begin
        rd(AD, r);
        chk(r == {24'h0, txb[i]}, "R5 random loopback", r, txb[i]);
      end
    end

    // R4 divider 0 means 65536, and clearing active aborts
    wr(AV, 32'd0);
    m_cpha = 0; m_cpol = 1;
    mode = cw(2'd2, 0, 1, 0, 0, 0, 0, 0, 0, 0, 3'b0);
    wr(AC, mode | 32'h30);
    wr(AD, 32'h3C);
    ecnt = 0;
    wr(AC, mode | 32'h80);
    wait (ecnt >= 2);
    chk(e_t[1] - e_t[0] == 32768, "R4 divider 0 half period", e_t[1] - e_t[0], 32768);
    wr(AC, mode);
    chk(sclk == 1'b1 && cs_o == 3'b111, "R4 abort returns to idle", {sclk, cs_o}, 4'b1111);
    repeat (10) @(negedge clk);
    rd(AC, r);
    chk(r[17] == 1'b0, "R4 aborted byte not received", r[17], 0);

    finish_run();
  end
endmodule